// File: doc/BRIEF.md
# I2C Message Sequencer

This block runs one complete I2C master message on a status-coded I2C master core, with no processor involved. The message is described by a few inputs: a 7-bit or 10-bit target address, a direction, a byte count, an option to skip the START and address phases, and an option to flip the direction bit. A pulse on `msg_start` begins the message. Bytes to transmit are taken from a valid/ready stream. Bytes received are put out as single-cycle pulses on a valid-qualified output. When the message ends, the block raises `done` for one cycle with a two-bit result code.

The core is driven through a register write port: a write strobe, a register select and a write byte. The core's interrupt flag, status byte and received byte are read directly as inputs. While the flag is set, the sequencer reads the status code, picks one action, and performs it as a data-register write, a control-register write, or both. It then waits for the flag again. A two-stage timeout guards each message. When it first expires, the message is marked aborting. When it expires a second time, the core is reset and re-initialized. An external abort request also marks the message aborting. A read and a write react differently to the aborting mark.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: After reset the block writes, one per cycle and starting the first cycle after reset is released: soft reset (select 5, byte 0x00), baud (select 3, byte {1'b0, BAUD_M, BAUD_N}), own address (select 0, 0x00), extended own address (select 4, 0x00), then control (select 2) 0x50. `busy` is high during this sequence. Register selects: 0 own address, 1 data, 2 control, 3 baud, 4 extended own address, 5 soft reset.
- R2: Control byte bits: 7 interrupt enable, 6 core enable, 5 START, 4 STOP, 3 flag (always written 0), 2 ACK enable. A message opens with control 0xE4, or 0xE0 if ACK enable has been cleared. Every other non-stop action writes 0xC4, or 0xC0 if ACK enable has been cleared. Every STOP writes 0x50.
- R3: On status 0x08 or 0x10 the first address byte is written to the data register (select 1), followed by control. For a 7-bit address this byte is {addr[6:0], dir}. The direction bit dir is msg_read XOR msg_rev.
- R4: For a 10-bit address the first byte is 0xF0 | addr[9:8]<<1 | dir. On status 0x18 or 0x40 the second byte, addr[7:0], is written.
- R5: On a write acknowledge (0x18 with a 7-bit address, 0xD0 or 0x28), the next stream byte is written while bytes remain. When none remain, STOP is issued and `done` reports result 0 (ok).
- R6: On a read address acknowledge (0x40 with a 7-bit address, or 0xE0) the block issues a continue, or a STOP if the count is zero. On 0x50 it emits the received byte on `rx_data`. ACK enable is cleared in every control write from the point where exactly one byte remains. On 0x58 it emits the final byte and issues STOP with result 0.
- R7: Status 0x20, 0x30 or 0x48 issues STOP and returns result 1 (no device).
- R8: Any other status re-runs the R1 initialization sequence and returns result 2 (I/O error).
- R9: With the no-start option, a read begins with a bare control write (0xC4). A write begins with the first stream byte followed by control 0xC4.
- R10: Once aborting is set, a read clears ACK enable at its next control write. A write issues STOP at its next write acknowledge, provided at least one data byte has already been sent.
- R11: TMO_CYC cycles after a message starts, the message is marked aborting and its result becomes 3 (timeout). If it is still unfinished after 2*TMO_CYC cycles, the R1 sequence runs and `done` reports 3.
- R12: A flag seen while idle produces a single STOP control write (0x50) and no `done` pulse.
- R13: `done` is a single-cycle pulse with `busy` low. `msg_start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_start | input | 1 | Begin a message (accepted only when idle) |
| msg_addr | input | 10 | Target address |
| msg_ten | input | 1 | 10-bit address mode |
| msg_read | input | 1 | 1 = read |
| msg_rev | input | 1 | Invert the direction bit |
| msg_nostart | input | 1 | Skip the START and address phases |
| msg_len | input | LEN_W | Byte count |
| abort_req | input | 1 | Request abort of the running message |
| tx_data | input | 8 | Transmit stream byte |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Transmit byte consumed when valid |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte pulse |
| core_irq | input | 1 | Core interrupt flag |
| core_status | input | 8 | Core status code |
| core_rdata | input | 8 | Core received data byte |
| core_we | output | 1 | Core register write strobe |
| core_sel | output | 3 | Core register select |
| core_wdata | output | 8 | Core register write byte |
| busy | output | 1 | Initializing or running a message |
| done | output | 1 | Message finished pulse |
| result | output | 2 | 0 ok, 1 no device, 2 I/O error, 3 timeout |

## Verification
The first write after a flag is seen lands two cycles later: one cycle to notice the flag and one cycle to decide. A data write and its control write fall on consecutive cycles. `done` and the last `rx_valid` pulse each rise one cycle after the closing STOP write and the decision cycle respectively. The bench's core model logs every write at the clock edge where the strobe is seen, and clears the flag on any control write. Checks compare the whole logged write sequence, the received-byte log and the result once `done` has been counted, sampling on the falling edge. For the timeout cases, the delays are chosen so that each event lands clearly between the first and the second expiry.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [2:0] {
        SEL_OWN  = 3'd0,
        SEL_DATA = 3'd1,
        SEL_CTRL = 3'd2,
        SEL_BAUD = 3'd3,
        SEL_XOWN = 3'd4,
        SEL_SRST = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_NODEV = 2'd1,
        RES_IOERR = 2'd2,
        RES_TMO   = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        ACT_CONT, ACT_ADDR1, ACT_ADDR2, ACT_SEND,
        ACT_RCV, ACT_RCV_STOP, ACT_STOP, ACT_FAULT
    } act_e;

    typedef enum logic [1:0] {CK_NORM, CK_START, CK_STOP} ctrl_kind_e;

    typedef struct packed {
        act_e  act;
        logic  dec_left;
        logic  clr_ack;
        res_e  res;
    } decision_t;

    typedef struct packed {
        logic [9:0] addr;
        logic       ten;
        logic       rd;
        logic       rev;
    } desc_t;

    localparam int CB_ACK   = 2;
    localparam int CB_STOP  = 4;
    localparam int CB_START = 5;
    localparam int CB_EN    = 6;
    localparam int CB_IE    = 7;

    localparam logic [7:0] ST_START     = 8'h08;
    localparam logic [7:0] ST_RSTART    = 8'h10;
    localparam logic [7:0] ST_WA_ACK    = 8'h18;
    localparam logic [7:0] ST_WA_NACK   = 8'h20;
    localparam logic [7:0] ST_WD_ACK    = 8'h28;
    localparam logic [7:0] ST_WD_NACK   = 8'h30;
    localparam logic [7:0] ST_RA_ACK    = 8'h40;
    localparam logic [7:0] ST_RA_NACK   = 8'h48;
    localparam logic [7:0] ST_RD_ACK    = 8'h50;
    localparam logic [7:0] ST_RD_NACK   = 8'h58;
    localparam logic [7:0] ST_WA2_ACK   = 8'hD0;
    localparam logic [7:0] ST_RA2_ACK   = 8'hE0;

    function automatic logic [7:0] ctrl_word(input logic ie, input logic start,
                                             input logic stop, input logic ack);
        logic [7:0] w;
        w           = '0;
        w[CB_IE]    = ie;
        w[CB_EN]    = 1'b1;
        w[CB_START] = start;
        w[CB_STOP]  = stop;
        w[CB_ACK]   = ack;
        return w;
    endfunction

endpackage

// File: rtl/i2cseq_addr.sv
module i2cseq_addr
    import i2cseq_pkg::*;
(
    input  desc_t      dsc,
    output logic [7:0] byte1,
    output logic [7:0] byte2
);
    logic dir;

    always_comb begin
        dir   = dsc.rd ^ dsc.rev;
        byte2 = dsc.addr[7:0];
        if (dsc.ten)
            byte1 = {5'b11110, dsc.addr[9:8], dir};
        else
            byte1 = {dsc.addr[6:0], dir};
    end
endmodule

// File: rtl/i2cseq_decoder.sv
module i2cseq_decoder
    import i2cseq_pkg::*;
(
    input  logic [7:0] status,
    input  logic       ten,
    input  logic       left0,
    input  logic       left1,
    input  logic       left2,
    input  logic       aborting,
    input  logic       sent_any,
    output decision_t  dec
);
    logic wr_ack;
    logic rd_addr;

    always_comb begin
        dec.act      = ACT_FAULT;
        dec.dec_left = 1'b0;
        dec.clr_ack  = 1'b0;
        dec.res      = RES_IOERR;
        wr_ack       = 1'b0;
        rd_addr      = 1'b0;

        case (status)
            ST_START, ST_RSTART: dec.act = ACT_ADDR1;
            ST_WA_ACK: begin
                if (ten) dec.act = ACT_ADDR2;
                else     wr_ack  = 1'b1;
            end
            ST_WA2_ACK, ST_WD_ACK: wr_ack = 1'b1;
            ST_RA_ACK: begin
                if (ten) dec.act = ACT_ADDR2;
                else     rd_addr = 1'b1;
            end
            ST_RA2_ACK: rd_addr = 1'b1;
            ST_RD_ACK: begin
                dec.act      = ACT_RCV;
                dec.dec_left = 1'b1;
                dec.clr_ack  = left2 | aborting;
            end
            ST_RD_NACK: begin
                dec.act = ACT_RCV_STOP;
                dec.res = RES_OK;
            end
            ST_WA_NACK, ST_WD_NACK, ST_RA_NACK: begin
                dec.act = ACT_STOP;
                dec.res = RES_NODEV;
            end
            default: dec.act = ACT_FAULT;
        endcase

        if (wr_ack) begin
            if (left0 || (aborting && sent_any)) begin
                dec.act = ACT_STOP;
                dec.res = RES_OK;
            end else begin
                dec.act      = ACT_SEND;
                dec.dec_left = 1'b1;
            end
        end

        if (rd_addr) begin
            if (left0) begin
                dec.act = ACT_STOP;
                dec.res = RES_OK;
            end else begin
                dec.act     = ACT_CONT;
                dec.clr_ack = left1 | aborting;
            end
        end
    end
endmodule

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
    parameter int TMO_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire1,
    output logic expire2
);
    localparam int TW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

    logic [TW-1:0] cnt;
    logic          phase;
    logic          at_end;

    assign at_end  = run && (cnt == LAST);
    assign expire1 = at_end && !phase;
    assign expire2 = at_end && phase;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (at_end) begin
            cnt   <= '0;
            phase <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_msg_sequencer.sv
module i2c_msg_sequencer
    import i2cseq_pkg::*;
#(
    parameter int         LEN_W   = 8,
    parameter int         TMO_CYC = 1000,
    parameter logic [3:0] BAUD_M  = 4'd2,
    parameter logic [2:0] BAUD_N  = 3'd3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             msg_start,
    input  logic [9:0]       msg_addr,
    input  logic             msg_ten,
    input  logic             msg_read,
    input  logic             msg_rev,
    input  logic             msg_nostart,
    input  logic [LEN_W-1:0] msg_len,
    input  logic             abort_req,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    input  logic             core_irq,
    input  logic [7:0]       core_status,
    input  logic [7:0]       core_rdata,
    output logic             core_we,
    output logic [2:0]       core_sel,
    output logic [7:0]       core_wdata,
    output logic             busy,
    output logic             done,
    output logic [1:0]       result
);
    localparam logic [2:0] INIT_LAST = 3'd4;

    typedef enum logic [2:0] {
        S_INIT, S_IDLE, S_WAIT, S_DECIDE, S_DATA, S_CTRL
    } st_e;

    st_e              st;
    logic [2:0]       init_step;
    desc_t            dsc;
    logic [LEN_W-1:0] left;
    logic             sent_any;
    logic             aborting;
    logic             ack_en;
    logic             tmo_hit;
    logic             msg_act;
    logic [7:0]       data_hold;
    logic             data_from_tx;
    ctrl_kind_e       kind;
    logic             finish;
    res_e             fin_res;
    logic             pend_done;
    res_e             pend_res;
    res_e             result_q;

    logic [7:0] byte1, byte2;
    decision_t  dec;
    logic       expire1, expire2;
    reg_sel_e   sel_c;

    i2cseq_addr u_addr (
        .dsc   (dsc),
        .byte1 (byte1),
        .byte2 (byte2)
    );

    i2cseq_decoder u_dec (
        .status   (core_status),
        .ten      (dsc.ten),
        .left0    (left == '0),
        .left1    (left == LEN_W'(1)),
        .left2    (left == LEN_W'(2)),
        .aborting (aborting),
        .sent_any (sent_any),
        .dec      (dec)
    );

    i2cseq_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (msg_act),
        .expire1 (expire1),
        .expire2 (expire2)
    );

    // Register write port
    always_comb begin
        core_we    = 1'b0;
        sel_c      = SEL_DATA;
        core_wdata = '0;
        tx_ready   = 1'b0;
        case (st)
            S_INIT: begin
                core_we = 1'b1;
                case (init_step)
                    3'd0:    begin sel_c = SEL_SRST; core_wdata = 8'h00; end
                    3'd1:    begin sel_c = SEL_BAUD; core_wdata = {1'b0, BAUD_M, BAUD_N}; end
                    3'd2:    begin sel_c = SEL_OWN;  core_wdata = 8'h00; end
                    3'd3:    begin sel_c = SEL_XOWN; core_wdata = 8'h00; end
                    default: begin sel_c = SEL_CTRL; core_wdata = ctrl_word(1'b0, 1'b0, 1'b1, 1'b0); end
                endcase
            end
            S_DATA: begin
                sel_c = SEL_DATA;
                if (data_from_tx) begin
                    tx_ready   = 1'b1;
                    core_we    = tx_valid;
                    core_wdata = tx_data;
                end else begin
                    core_we    = 1'b1;
                    core_wdata = data_hold;
                end
            end
            S_CTRL: begin
                core_we = 1'b1;
                sel_c   = SEL_CTRL;
                if (kind == CK_STOP)
                    core_wdata = ctrl_word(1'b0, 1'b0, 1'b1, 1'b0);
                else
                    core_wdata = ctrl_word(1'b1, kind == CK_START, 1'b0, ack_en);
            end
            default: core_we = 1'b0;
        endcase
    end

    assign core_sel = sel_c;
    assign busy     = (st != S_IDLE);
    assign result   = result_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= S_INIT;
            init_step    <= '0;
            dsc          <= '0;
            left         <= '0;
            sent_any     <= 1'b0;
            aborting     <= 1'b0;
            ack_en       <= 1'b1;
            tmo_hit      <= 1'b0;
            msg_act      <= 1'b0;
            data_hold    <= '0;
            data_from_tx <= 1'b0;
            kind         <= CK_NORM;
            finish       <= 1'b0;
            fin_res      <= RES_OK;
            pend_done    <= 1'b0;
            pend_res     <= RES_OK;
            result_q     <= RES_OK;
            done         <= 1'b0;
            rx_valid     <= 1'b0;
            rx_data      <= '0;
        end else begin
            done     <= 1'b0;
            rx_valid <= 1'b0;

            case (st)
                S_INIT: begin
                    if (init_step == INIT_LAST) begin
                        st        <= S_IDLE;
                        init_step <= '0;
                        if (pend_done) begin
                            done      <= 1'b1;
                            result_q  <= pend_res;
                            pend_done <= 1'b0;
                        end
                    end else begin
                        init_step <= init_step + 1'b1;
                    end
                end

                S_IDLE: begin
                    if (msg_start) begin
                        dsc.addr     <= msg_addr;
                        dsc.ten      <= msg_ten;
                        dsc.rd       <= msg_read;
                        dsc.rev      <= msg_rev;
                        left         <= msg_len;
                        sent_any     <= 1'b0;
                        aborting     <= abort_req;
                        ack_en       <= 1'b1;
                        tmo_hit      <= 1'b0;
                        msg_act      <= 1'b1;
                        finish       <= 1'b0;
                        data_from_tx <= 1'b0;
                        if (msg_nostart) begin
                            if (msg_read) begin
                                kind <= CK_NORM;
                                st   <= S_CTRL;
                            end else begin
                                data_from_tx <= 1'b1;
                                left         <= msg_len - 1'b1;
                                sent_any     <= 1'b1;
                                st           <= S_DATA;
                            end
                        end else begin
                            kind <= CK_START;
                            st   <= S_CTRL;
                        end
                    end else if (core_irq) begin
                        kind   <= CK_STOP;
                        finish <= 1'b0;
                        st     <= S_CTRL;
                    end
                end

                S_WAIT: begin
                    if (core_irq) st <= S_DECIDE;
                end

                S_DECIDE: begin
                    if (dec.clr_ack)  ack_en <= 1'b0;
                    if (dec.dec_left) left   <= left - 1'b1;
                    case (dec.act)
                        ACT_ADDR1: begin
                            data_hold    <= byte1;
                            data_from_tx <= 1'b0;
                            st           <= S_DATA;
                        end
                        ACT_ADDR2: begin
                            data_hold    <= byte2;
                            data_from_tx <= 1'b0;
                            st           <= S_DATA;
                        end
                        ACT_SEND: begin
                            data_from_tx <= 1'b1;
                            sent_any     <= 1'b1;
                            st           <= S_DATA;
                        end
                        ACT_CONT: begin
                            kind <= CK_NORM;
                            st   <= S_CTRL;
                        end
                        ACT_RCV: begin
                            rx_valid <= 1'b1;
                            rx_data  <= core_rdata;
                            kind     <= CK_NORM;
                            st       <= S_CTRL;
                        end
                        ACT_RCV_STOP: begin
                            rx_valid <= 1'b1;
                            rx_data  <= core_rdata;
                            kind     <= CK_STOP;
                            finish   <= 1'b1;
                            fin_res  <= tmo_hit ? RES_TMO : RES_OK;
                            st       <= S_CTRL;
                        end
                        ACT_STOP: begin
                            kind    <= CK_STOP;
                            finish  <= 1'b1;
                            fin_res <= tmo_hit ? RES_TMO : dec.res;
                            st      <= S_CTRL;
                        end
                        default: begin
                            st        <= S_INIT;
                            init_step <= '0;
                            pend_done <= 1'b1;
                            pend_res  <= RES_IOERR;
                            msg_act   <= 1'b0;
                        end
                    endcase
                end

                S_DATA: begin
                    if (!data_from_tx || tx_valid) begin
                        kind <= CK_NORM;
                        st   <= S_CTRL;
                    end
                end

                S_CTRL: begin
                    if (kind == CK_STOP) begin
                        st      <= S_IDLE;
                        msg_act <= 1'b0;
                        if (finish) begin
                            done     <= 1'b1;
                            result_q <= fin_res;
                        end
                    end else begin
                        st <= S_WAIT;
                    end
                end

                default: st <= S_IDLE;
            endcase

            if (msg_act && abort_req) aborting <= 1'b1;
            if (expire1) begin
                aborting <= 1'b1;
                tmo_hit  <= 1'b1;
            end
            if (expire2 && st != S_INIT) begin
                st        <= S_INIT;
                init_step <= '0;
                pend_done <= 1'b1;
                pend_res  <= RES_TMO;
                msg_act   <= 1'b0;
                finish    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_msg_sequencer_chk.sv
module i2c_msg_sequencer_chk (
    input logic       clk,
    input logic       rst,
    input logic       core_we,
    input logic [2:0] core_sel,
    input logic [7:0] core_wdata,
    input logic       tx_ready,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic       rx_valid,
    input logic       busy,
    input logic       done
);
    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R13
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R1
    init_first_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (core_we && core_sel == 3'd5 && busy));

    // R5
    tx_write_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && tx_valid) |-> (core_we && core_sel == 3'd1 && core_wdata == tx_data));

    // R2
    ctrl_form_chk: assert property (@(posedge clk) disable iff (rst)
        (core_we && core_sel == 3'd2) |-> (!(core_wdata[4] && core_wdata[5]) && !core_wdata[3] && core_wdata[6]));

    // R6
    rx_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> busy);
endmodule

bind i2c_msg_sequencer i2c_msg_sequencer_chk u_chk (.*);

// File: tb/tb_i2c_msg_sequencer.sv
module tb_i2c_msg_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       msg_start = 1'b0;
    logic [9:0] msg_addr = '0;
    logic       msg_ten = 1'b0, msg_read = 1'b0, msg_rev = 1'b0, msg_nostart = 1'b0;
    logic [7:0] msg_len = '0;
    logic       abort_req = 1'b0;
    logic [7:0] tx_data;
    logic       tx_valid = 1'b1;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       core_irq;
    logic [7:0] core_status, core_rdata;
    logic       core_we;
    logic [2:0] core_sel;
    logic [7:0] core_wdata;
    logic       busy, done;
    logic [1:0] result;

    always #5 clk = ~clk;

    i2c_msg_sequencer #(.LEN_W(8), .TMO_CYC(64)) dut (.*);

    // core model
    logic [7:0] scr_s [16];
    logic [7:0] scr_d [16];
    int         scr_w [16];
    int         sn = 0, si, cnt;
    logic       scr_ld = 1'b0, inj = 1'b0;
    logic       flag;
    logic [7:0] stat, rdat;
    assign core_irq    = flag;
    assign core_status = stat;
    assign core_rdata  = rdat;

    always @(posedge clk) begin
        if (rst || scr_ld) begin
            flag <= 1'b0; si <= 0; cnt <= -1; stat <= 8'hF8; rdat <= 8'h00;
        end else if (inj) begin
            flag <= 1'b1; stat <= 8'h28;
        end else if (core_we && core_sel == 3'd2) begin
            flag <= 1'b0;
            cnt  <= (si < sn) ? scr_w[si] : -1;
        end else if (cnt > 0) begin
            cnt <= cnt - 1;
        end else if (cnt == 0) begin
            flag <= 1'b1; stat <= scr_s[si]; rdat <= scr_d[si];
            si <= si + 1; cnt <= -1;
        end
    end

    // transmit source
    logic [7:0] tx_arr [8];
    int         tx_i;
    assign tx_data = tx_arr[tx_i];
    always @(posedge clk) begin
        if (rst || scr_ld) tx_i <= 0;
        else if (tx_ready && tx_valid) tx_i <= tx_i + 1;
    end

    // logs
    logic [2:0] lg_s [32];
    logic [7:0] lg_d [32];
    logic [7:0] rx_lg [8];
    int ln, rn, dn;
    logic [1:0] dres;
    always @(posedge clk) begin
        if (rst || scr_ld) begin ln <= 0; rn <= 0; end
        else begin
            if (core_we && ln < 32) begin lg_s[ln] <= core_sel; lg_d[ln] <= core_wdata; ln <= ln + 1; end
            if (rx_valid && rn < 8) begin rx_lg[rn] <= rx_data; rn <= rn + 1; end
        end
        if (rst) dn <= 0;
        else if (done) begin dn <= dn + 1; dres <= result; end
    end

    int chk = 0, err = 0, cyc = 0;
    logic [2:0] exp_s [32];
    logic [7:0] exp_d [32];
    int en;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        chk++;
        if (!ok) begin
            err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", chk, err);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            chk++; err++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            summary();
            $finish;
        end
    end

    task automatic prep();
        @(negedge clk); scr_ld = 1'b1; sn = 0; en = 0;
        @(negedge clk); scr_ld = 1'b0;
    endtask

    task automatic scr(input logic [7:0] s, input logic [7:0] d, input int w);
        scr_s[sn] = s; scr_d[sn] = d; scr_w[sn] = w; sn++;
    endtask

    task automatic expw(input logic [2:0] s, input logic [7:0] d);
        exp_s[en] = s; exp_d[en] = d; en++;
    endtask

    task automatic exp_init();
        expw(3'd5, 8'h00); expw(3'd3, 8'h13); expw(3'd0, 8'h00);
        expw(3'd4, 8'h00); expw(3'd2, 8'h50);
    endtask

    task automatic cmp_log(input string tag);
        int bad = -1;
        for (int i = 0; i < en; i++)
            if (bad < 0 && i < ln && (lg_s[i] != exp_s[i] || lg_d[i] != exp_d[i])) bad = i;
        check(ln == en, {tag, " write count"}, ln, en);
        if (bad >= 0)
            check(1'b0, {tag, " write sequence"}, {lg_s[bad], lg_d[bad]}, {exp_s[bad], exp_d[bad]});
        else
            check(1'b1, tag, 0, 0);
    endtask

    task automatic go(input logic [9:0] a, input logic ten, input logic rd,
                      input logic rv, input logic ns, input logic [7:0] len);
        @(negedge clk);
        msg_addr = a; msg_ten = ten; msg_read = rd; msg_rev = rv; msg_nostart = ns; msg_len = len;
        msg_start = 1'b1;
        @(negedge clk); msg_start = 1'b0;
    endtask

    task automatic wait_done(input int d0, input int maxc, input string tag);
        for (int k = 0; k < maxc && dn == d0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(dn == d0 + 1, {tag, " done count"}, dn, d0 + 1);
    endtask

    // R1, R13
    task automatic t_reset();
        @(negedge clk); rst = 1'b0;
        check(busy == 1'b1, "R1 busy during init", busy, 1);
        repeat (8) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 idle after init", {busy, done}, 0);
        en = 0; exp_init(); cmp_log("R1 init sequence");
    endtask

    // R3, R5, R13
    task automatic t_write7();
        int d0;
        prep(); tx_arr[0] = 8'hA5; tx_arr[1] = 8'h3C;
        scr(8'h08, 0, 3); scr(8'h18, 0, 3); scr(8'h28, 0, 3); scr(8'h28, 0, 3);
        d0 = dn;
        go(10'h03A, 0, 0, 0, 0, 8'd2);
        @(negedge clk); msg_addr = 10'h011; msg_start = 1'b1; // ignored while busy (R13)
        @(negedge clk); msg_start = 1'b0;
        wait_done(d0, 200, "R5 write");
        expw(2, 8'hE4); expw(1, 8'h74); expw(2, 8'hC4); expw(1, 8'hA5); expw(2, 8'hC4);
        expw(1, 8'h3C); expw(2, 8'hC4); expw(2, 8'h50);
        cmp_log("R3 R5 R13 write7");
        check(dres == 2'd0, "R5 result", dres, 0);
        check(busy == 1'b0, "R13 idle after message", busy, 0);
    endtask

    // R6
    task automatic t_read7();
        int d0;
        prep();
        scr(8'h08, 0, 3); scr(8'h40, 0, 3); scr(8'h50, 8'h11, 3); scr(8'h50, 8'h22, 3); scr(8'h58, 8'h33, 3);
        d0 = dn;
        go(10'h051, 0, 1, 0, 0, 8'd3);
        wait_done(d0, 200, "R6 read");
        expw(2, 8'hE4); expw(1, 8'hA3); expw(2, 8'hC4); expw(2, 8'hC4); expw(2, 8'hC4);
        expw(2, 8'hC0); expw(2, 8'h50);
        cmp_log("R6 read7");
        check(rn == 3 && rx_lg[0] == 8'h11 && rx_lg[1] == 8'h22 && rx_lg[2] == 8'h33,
              "R6 rx bytes", {rx_lg[0], rx_lg[1], rx_lg[2]}, 24'h112233);
        check(dres == 2'd0, "R6 result", dres, 0);
    endtask

    // R4
    task automatic t_ten_read();
        int d0;
        prep();
        scr(8'h08, 0, 3); scr(8'h40, 0, 3); scr(8'hE0, 0, 3); scr(8'h58, 8'h77, 3);
        d0 = dn;
        go(10'h2C5, 1, 0, 1, 0, 8'd1);
        wait_done(d0, 200, "R4 ten");
        expw(2, 8'hE4); expw(1, 8'hF5); expw(2, 8'hC4); expw(1, 8'hC5); expw(2, 8'hC4);
        expw(2, 8'hC0); expw(2, 8'h50);
        cmp_log("R4 ten-bit reversed read");
        check(rn == 1 && rx_lg[0] == 8'h77, "R4 rx byte", rx_lg[0], 8'h77);
    endtask

    // R7
    task automatic t_nodev();
        int d0;
        prep(); tx_arr[0] = 8'h01;
        scr(8'h08, 0, 3); scr(8'h20, 0, 3);
        d0 = dn;
        go(10'h010, 0, 0, 0, 0, 8'd1);
        wait_done(d0, 200, "R7 nodev");
        expw(2, 8'hE4); expw(1, 8'h20); expw(2, 8'hC4); expw(2, 8'h50);
        cmp_log("R7 nodev writes");
        check(dres == 2'd1, "R7 result", dres, 1);
    endtask

    // R8
    task automatic t_fault();
        int d0;
        prep();
        scr(8'h08, 0, 3); scr(8'h38, 0, 3);
        d0 = dn;
        go(10'h010, 0, 0, 0, 0, 8'd1);
        wait_done(d0, 200, "R8 fault");
        expw(2, 8'hE4); expw(1, 8'h20); expw(2, 8'hC4); exp_init();
        cmp_log("R8 fault reinit");
        check(dres == 2'd2, "R8 result", dres, 2);
    endtask

    // R9
    task automatic t_nostart();
        int d0;
        prep();
        scr(8'h50, 8'h9A, 3); scr(8'h58, 8'h9B, 3);
        d0 = dn;
        go(10'h000, 0, 1, 0, 1, 8'd2);
        wait_done(d0, 200, "R9 nostart read");
        expw(2, 8'hC4); expw(2, 8'hC0); expw(2, 8'h50);
        cmp_log("R9 nostart read");
        check(rn == 2 && rx_lg[0] == 8'h9A && rx_lg[1] == 8'h9B, "R9 rx", {rx_lg[0], rx_lg[1]}, 16'h9A9B);

        prep(); tx_arr[0] = 8'h5E; tx_arr[1] = 8'h6F;
        scr(8'h28, 0, 3); scr(8'h28, 0, 3);
        d0 = dn;
        go(10'h000, 0, 0, 0, 1, 8'd2);
        wait_done(d0, 200, "R9 nostart write");
        expw(1, 8'h5E); expw(2, 8'hC4); expw(1, 8'h6F); expw(2, 8'hC4); expw(2, 8'h50);
        cmp_log("R9 nostart write");
    endtask

    // R10
    task automatic t_abort_read();
        int d0;
        prep();
        scr(8'h08, 0, 3); scr(8'h40, 0, 3); scr(8'h58, 8'h44, 3);
        d0 = dn;
        go(10'h051, 0, 1, 0, 0, 8'd3);
        abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
        wait_done(d0, 200, "R10 abort read");
        expw(2, 8'hE4); expw(1, 8'hA3); expw(2, 8'hC4); expw(2, 8'hC0); expw(2, 8'h50);
        cmp_log("R10 abort read");
        check(dres == 2'd0, "R10 abort read result", dres, 0);
    endtask

    // R10, R11
    task automatic t_tmo_write();
        int d0;
        prep(); tx_arr[0] = 8'hA5; tx_arr[1] = 8'h3C;
        scr(8'h08, 0, 3); scr(8'h18, 0, 3); scr(8'h28, 0, 90);
        d0 = dn;
        go(10'h03A, 0, 0, 0, 0, 8'd2);
        wait_done(d0, 300, "R11 late ack");
        expw(2, 8'hE4); expw(1, 8'h74); expw(2, 8'hC4); expw(1, 8'hA5); expw(2, 8'hC4); expw(2, 8'h50);
        cmp_log("R10 abort write after first expiry");
        check(dres == 2'd3, "R11 timeout result", dres, 3);
    endtask

    // R11
    task automatic t_hang();
        int d0;
        prep();
        scr(8'h08, 0, 3);
        d0 = dn;
        go(10'h03A, 0, 0, 0, 0, 8'd1);
        repeat (100) @(negedge clk);
        check(dn == d0 && busy, "R11 still busy before second expiry", dn - d0, 0);
        wait_done(d0, 300, "R11 hang");
        expw(2, 8'hE4); expw(1, 8'h74); expw(2, 8'hC4); exp_init();
        cmp_log("R11 hang reinit");
        check(dres == 2'd3, "R11 hang result", dres, 3);
    endtask

    // R12
    task automatic t_remnant();
        int d0;
        prep();
        d0 = dn;
        @(negedge clk); inj = 1'b1; @(negedge clk); inj = 1'b0;
        repeat (20) @(negedge clk);
        expw(2, 8'h50);
        cmp_log("R12 idle flag stop");
        check(dn == d0, "R12 no done", dn - d0, 0);
        check(busy == 1'b0, "R12 idle", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_write7();
        t_read7();
        t_ten_read();
        t_nodev();
        t_fault();
        t_nostart();
        t_abort_read();
        t_tmo_write();
        t_hang();
        t_remnant();
        summary();
        $finish;
    end
endmodule